// File: doc/BRIEF.md
# Two-Wire DAC Code Slave with Power-Down Control

This block is a write-only slave on a two-wire serial bus (SCL clock, SDA data) that owns the 8-bit code register of a voltage DAC and a power-down flag. Both lines are oversampled by a fast system clock. Each line is synchronised and filtered, and then the block detects START, repeated START and STOP. It matches a 7-bit address and treats the bit that normally gives the transfer direction as a power-down request. A transaction has an address byte and one data byte. It takes effect only when a STOP follows that data byte.

The slave drives SDA only through an open-drain pull-down enable, and only in the acknowledge slot. The committed code, the power-down flag and an output clamp enable are visible to the analog side. The clamp grounds the DAC output while the block is powered down. A partial or aborted transfer never changes these outputs.

Top module: `dac_serial_slave`

## Requirements
- R1: After reset, code_o is 0, shdn_o and clamp_o are 0, and sda_pull_o is 0.
- R2: The 7-bit address is {5'b01100, strap_i[1], strap_i[0]}, sent MSB first as bits 7..1 of the first byte after START. For each strap setting, the matching address is acknowledged by sda_pull_o=1 in the 9th SCL high period.
- R3: A non-matching first byte gets no acknowledge, and neither does any later byte of the same transfer. This includes the all-zero general call byte and the 11110xx0 prefix used for 10-bit addressing. The transfer changes no output.
- R4: Bit 0 of the address byte is the power-down request: 1 powers down, 0 resumes. The address is acknowledged for either value.
- R5: The second byte is the DAC code, MSB first, and it is acknowledged. code_o stays at its old value until a STOP follows the acknowledged byte, and takes the new code after that STOP.
- R6: A STOP or a repeated START right after the address byte leaves code_o and shdn_o unchanged.
- R7: With a power-down request, the slave releases SDA through all 8 data bits, so the master reads 0xFF. The STOP then sets shdn_o and clamp_o to 1, and code_o keeps its old value.
- R8: A byte after the data byte gets no acknowledge, and the pending update is discarded at the following STOP.
- R9: A repeated START after the data byte discards the pending update and opens a new address phase, which commits normally.
- R10: sda_pull_o is asserted only in the acknowledge slot. It rises only while SCL is low, is never set during a data or address bit, and is released after STOP.
- R11: An SDA pulse shorter than FILT_LEN system clocks while SCL is high is not treated as START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | 2 | Address strap bits; bit 1 gives address bit 1 and bit 0 gives address bit 0 |
| sda_pull_o | output | 1 | Open-drain pull-down enable for SDA |
| code_o | output | 8 | Committed DAC code |
| shdn_o | output | 1 | Committed power-down flag |
| clamp_o | output | 1 | Output clamp to ground, active while powered down |

## Verification
The assertions rely on the bus obeying the protocol at the filtered level. SDA changes only while SCL is low, except at START and STOP. Every SCL level lasts longer than the synchroniser plus the filter, so each edge is seen once and in order. The bench holds every bus phase for 16 system clocks, well above the roughly six-cycle input latency. It changes SDA only in SCL-low phases, except for deliberate START/STOP edges and the short glitches used for R11. It models the open-drain line by ANDing the master's drive with the slave's release.

// File: rtl/dss_pkg.sv
package dss_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [4:0] ADDR_HI = 5'b01100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_PEND,
    ST_SKIP
  } dss_state_e;
endpackage

// File: rtl/dss_line_filter.sv
module dss_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   out_q;
  logic                   s_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  assign s_in = sync_q[SYNC_STAGES-1];

  // accept a new level only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (s_in == out_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      cnt_q <= '0;
      out_q <= s_in;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/dss_bus_cond.sv
module dss_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/dss_proto.sv
module dss_proto
  import dss_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        strap_i,
  input  logic              scl_lvl_i,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] code_o,
  output logic              shdn_o
);
  dss_state_e        state_q, state_n;
  logic [3:0]        cnt_q, cnt_n;
  logic [BYTE_W-1:0] sh_q, sh_n;
  logic [BYTE_W-1:0] pend_q, pend_n;
  logic              req_q, req_n;
  logic              pull_q;
  logic [BYTE_W-1:0] code_q, code_n;
  logic              shdn_q, shdn_n;
  logic              addr_hit;

  assign addr_hit = (sh_q[7:1] == {ADDR_HI, strap_i});

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    pend_n  = pend_q;
    req_n   = req_q;
    code_n  = code_q;
    shdn_n  = shdn_q;
    if (start_i) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
    end else if (stop_i) begin
      if (state_q == ST_PEND) begin
        shdn_n = req_q;
        if (!req_q) code_n = pend_q;
      end
      state_n = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise_i) begin
            sh_n  = {sh_q[BYTE_W-2:0], sda_lvl_i};
            cnt_n = cnt_q + 1'b1;
          end else if (scl_fall_i && cnt_q == 4'd8) begin
            cnt_n = '0;
            if (state_q == ST_DATA) begin
              pend_n  = sh_q;
              state_n = ST_DATA_ACK;
            end else if (addr_hit) begin
              req_n   = sh_q[0];
              state_n = ST_ADDR_ACK;
            end else begin
              state_n = ST_SKIP;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall_i) state_n = ST_DATA;
        ST_DATA_ACK: if (scl_fall_i) state_n = ST_PEND;
        // a full SCL pulse without STOP means an extra byte: drop the update
        ST_PEND:     if (scl_fall_i) state_n = ST_SKIP;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      pend_q  <= '0;
      req_q   <= 1'b0;
      pull_q  <= 1'b0;
      code_q  <= '0;
      shdn_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      pend_q  <= pend_n;
      req_q   <= req_n;
      pull_q  <= (state_n == ST_ADDR_ACK) || (state_n == ST_DATA_ACK);
      code_q  <= code_n;
      shdn_q  <= shdn_n;
    end
  end

  assign sda_pull_o = pull_q;
  assign code_o     = code_q;
  assign shdn_o     = shdn_q;

  // R10
  pull_rise_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_q) |-> !scl_lvl_i);
  // R10
  pull_release_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !pull_q);
  // R5
  code_only_at_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q != $past(code_q)) |-> $past(stop_i));
  // R7
  shdn_only_at_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shdn_q != $past(shdn_q)) |-> $past(stop_i));
  // R2
  bit_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 4'd8);
endmodule

// File: rtl/dac_serial_slave.sv
module dac_serial_slave
  import dss_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        strap_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] code_o,
  output logic              shdn_o,
  output logic              clamp_o
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw, filt;
  logic scl_rise, scl_fall, start, stop;
  logic shdn;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    dss_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(filt[g])
    );
  end

  dss_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (filt[0]),
    .sda_i     (filt[1]),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start),
    .stop_o    (stop)
  );

  dss_proto u_proto (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strap_i   (strap_i),
    .scl_lvl_i (filt[0]),
    .sda_lvl_i (filt[1]),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .start_i   (start),
    .stop_i    (stop),
    .sda_pull_o(sda_pull_o),
    .code_o    (code_o),
    .shdn_o    (shdn)
  );

  assign shdn_o  = shdn;
  assign clamp_o = shdn;
endmodule

// File: tb/dac_serial_slave_bench.sv
module dac_serial_slave_bench;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic [1:0] strap = 2'd0;
  logic pull, shdn, clamp;
  logic [7:0] code;
  wire sda_line;
  logic glitch_en = 1'b0;
  int checks = 0;
  int errors = 0;
  logic [7:0] exp_code = 8'h00;
  logic exp_shdn = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = m_sda & ~pull;

  dac_serial_slave u_dac_serial_slave (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .strap_i   (strap),
    .sda_pull_o(pull),
    .code_o    (code),
    .shdn_o    (shdn),
    .clamp_o   (clamp)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req);
    @(negedge clk);
    chk(code == exp_code, req, code, exp_code);
    chk(shdn == exp_shdn, req, shdn, exp_shdn);
    chk(clamp == exp_shdn, req, clamp, exp_shdn);
  endtask

  task automatic qwait;
    repeat (Q) @(posedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; qwait;
    m_scl = 1'b1; qwait;
    m_sda = 1'b0; qwait;
    m_scl = 1'b0; qwait;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; qwait;
    m_scl = 1'b1; qwait;
    m_sda = 1'b1; qwait;
    qwait;
  endtask

  task automatic xfer_bit(input logic b, output logic rd, output logic pulled);
    m_sda = b; qwait;
    m_scl = 1'b1;
    repeat (6) @(posedge clk);
    if (glitch_en && b) begin
      m_sda = 1'b0;
      repeat (2) @(posedge clk);
      m_sda = 1'b1;
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd = sda_line;
    pulled = pull;
    qwait;
    m_scl = 1'b0;
  endtask

  task automatic xfer_byte(input logic [7:0] b, output logic [7:0] rd, output logic ack,
                           output logic stray);
    logic r, p;
    stray = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(b[i], r, p);
      rd[i] = r;
      stray |= p;
    end
    xfer_bit(1'b1, r, p);
    ack = p;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic ack, stray;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    chk(code == 8'h00, "R1", code, 0);
    chk(shdn == 1'b0, "R1", shdn, 0);
    chk(clamp == 1'b0, "R1", clamp, 0);
    chk(pull == 1'b0, "R1", pull, 0);
    rst_n = 1'b1;
    qwait;

    // R2/R3/R5 sweep over strap settings and the eight nearby addresses
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      qwait;
      for (int a = 0; a < 8; a++) begin
        logic [7:0] ab, d;
        bit match;
        ab = 8'((8'h30 + a) << 1);
        d = 8'(s * 37 + a * 11 + 5);
        match = (a < 4) && ((a & 3) == s);
        bus_start;
        xfer_byte(ab, rd, ack, stray);
        chk(ack == match, match ? "R2" : "R3", ack, match);
        chk(!stray, "R10", stray, 0);
        xfer_byte(d, rd, ack, stray);
        chk(ack == match, match ? "R5" : "R3", ack, match);
        check_out(match ? "R5" : "R3");
        bus_stop;
        if (match) exp_code = d;
        check_out(match ? "R5" : "R3");
        @(negedge clk);
        chk(pull == 1'b0, "R10", pull, 0);
      end
    end

    strap = 2'd2;
    qwait;

    // R4/R7 power-down read: master clocks out all ones
    bus_start;
    xfer_byte(8'h65, rd, ack, stray);
    chk(ack, "R4", ack, 1);
    xfer_byte(8'hFF, rd, ack, stray);
    chk(rd == 8'hFF, "R7", rd, 8'hFF);
    chk(!stray, "R7", stray, 0);
    bus_stop;
    exp_shdn = 1'b1;
    check_out("R7");

    // R6 stop right after address
    bus_start;
    xfer_byte(8'h64, rd, ack, stray);
    chk(ack, "R4", ack, 1);
    bus_stop;
    check_out("R6");

    // R6 repeated start right after address, then stop
    bus_start;
    xfer_byte(8'h64, rd, ack, stray);
    bus_start;
    bus_stop;
    check_out("R6");

    // R4 resume with a new code
    bus_start;
    xfer_byte(8'h64, rd, ack, stray);
    xfer_byte(8'h80, rd, ack, stray);
    bus_stop;
    exp_code = 8'h80;
    exp_shdn = 1'b0;
    check_out("R4");

    // R8 third byte
    bus_start;
    xfer_byte(8'h64, rd, ack, stray);
    xfer_byte(8'h11, rd, ack, stray);
    xfer_byte(8'h22, rd, ack, stray);
    chk(!ack, "R8", ack, 0);
    bus_stop;
    check_out("R8");

    // R9 repeated start after data byte
    bus_start;
    xfer_byte(8'h64, rd, ack, stray);
    xfer_byte(8'h33, rd, ack, stray);
    bus_start;
    check_out("R9");
    xfer_byte(8'h64, rd, ack, stray);
    chk(ack, "R9", ack, 1);
    xfer_byte(8'h44, rd, ack, stray);
    bus_stop;
    exp_code = 8'h44;
    check_out("R9");

    // R3 general call and 10-bit prefix
    for (int k = 0; k < 2; k++) begin
      bus_start;
      xfer_byte(k == 0 ? 8'h00 : 8'hF0, rd, ack, stray);
      chk(!ack, "R3", ack, 0);
      xfer_byte(8'h55, rd, ack, stray);
      chk(!ack, "R3", ack, 0);
      bus_stop;
      check_out("R3");
    end

    // R11 short SDA glitches while SCL high are ignored
    glitch_en = 1'b1;
    bus_start;
    xfer_byte(8'h64, rd, ack, stray);
    chk(ack, "R11", ack, 1);
    xfer_byte(8'hA5, rd, ack, stray);
    glitch_en = 1'b0;
    bus_stop;
    exp_code = 8'hA5;
    check_out("R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule